// File: doc/BRIEF.md
# Serial Configuration Memory Readout Controller

This block is the read side of a bit-serial configuration store that loads an SRAM-based programmable logic device. The bit image is fixed at elaboration through a parameter. On every rising edge of the configuration clock one more stored bit is put on a three-state data pin. Bit index 0 goes out first and index DEPTH-1 goes out last.

A combined reset/output-enable pin clears the read position and releases the data pin. Its active level is taken from four configuration bytes that are latched at power-up. A chip-enable input puts the block into standby, which also releases the pin. Once the final bit has been read, the block releases the data line and pulls an active-low cascade output. That output lets the next memory in a chain take over the shared data line.

Top module: `cfgrd_reader`

## Requirements
- R1: While `por_n` is low, `data_drv` is 0 and `cascade_n` is 1. The read position is cleared, and the reset polarity is loaded from the `CFG_WORD` parameter.
- R2: After the first clock edge at which the reset level and standby are both absent, `data_drv` is 1 and `data_pin` shows `IMAGE[0]`. Each further edge shows the next index, in order, one bit per edge.
- R3: If `rso` is at the reset level when a clock edge occurs, the read position goes back to bit 0 and the cascade state is cleared. From that edge on, `data_drv` is 0 and `cascade_n` is 1. After the reset level is removed, the stream restarts at `IMAGE[0]`.
- R4: The reset level of `rso` is high only when all four bytes of `CFG_WORD` equal 8'h00. For any other value, including the default 32'hFFFF_FFFF, the reset level is low and a high `rso` enables the output.
- R5: If `ce_n` is high at a clock edge, then from that edge `data_drv` is 0, whatever the output-enable state is. The bit being shown when standby starts counts as read. When `ce_n` returns low, the stream continues with the next unread bit.
- R6: The edge after the one at which `IMAGE[DEPTH-1]` was shown drives `cascade_n` low and `data_drv` low. After that the read position stops advancing.
- R7: Once the last bit has been read, `cascade_n` goes high from any edge at which standby is sampled. It goes low again when standby ends without a reset. A reset ends the cascade state.
- R8: The read position never exceeds DEPTH-1. It advances by exactly one per edge while a bit is being shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; every rising edge reads the next bit |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rso | input | 1 | Combined reset/output enable; its reset level is set by `CFG_WORD` |
| data_pin | output | 1 | Serial data; high impedance when not driving |
| data_drv | output | 1 | High when `data_pin` is actively driven |
| cascade_n | output | 1 | Active-low handoff to the next memory in the chain |

## Verification
A continuous read of the whole array compares every bit in order with the image. This separates correct ordering from off-by-one starts and dropped or repeated bits at either end. A read cut short by a reset shows whether the position really returns to 0 rather than resuming. A read paused by standby shows the opposite: the stream must resume, losing no bit and repeating none. A second instance configured for a high reset level runs alongside the default one. Driving both with the same raw `rso` level separates the two polarities, and standby toggled after the last bit isolates the cascade output's behaviour.

// File: rtl/cfgrd_pkg.sv
`timescale 1ns/1ps
package cfgrd_pkg;

   localparam int POL_BYTES = 4;
   localparam int CFG_W     = 8 * POL_BYTES;
   localparam logic [7:0] HIGH_POL_CODE = 8'h00;

   // Returns 1 when the stored bytes select an active-high reset level.
   function automatic logic pol_from_cfg(input logic [CFG_W-1:0] word);
      logic all_match;
      all_match = 1'b1;
      for (int b = 0; b < POL_BYTES; b++) begin
         if (word[8*b +: 8] != HIGH_POL_CODE) all_match = 1'b0;
      end
      return all_match;
   endfunction

endpackage

// File: rtl/cfgrd_polarity.sv
`timescale 1ns/1ps
module cfgrd_polarity
   import cfgrd_pkg::*;
#(
   parameter logic [CFG_W-1:0] CFG_WORD = '1
) (
   input  logic clk,
   input  logic por_n,
   input  logic rso,
   output logic rst_seen,
   output logic rst_q
);

   logic hi_pol;

   // Polarity latched once at power-up, then held.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) hi_pol <= pol_from_cfg(CFG_WORD);
      else        hi_pol <= hi_pol;
   end

   assign rst_seen = (rso == hi_pol);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) rst_q <= 1'b1;
      else        rst_q <= rst_seen;
   end

   // R4
   pol_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
      $stable(hi_pol));

   // R3
   rst_track_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_seen |=> rst_q);

endmodule

// File: rtl/cfgrd_counter.sv
`timescale 1ns/1ps
module cfgrd_counter #(
   parameter int DEPTH = 48,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          clear,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          done
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         addr <= '0;
         done <= 1'b0;
      end else if (clear) begin
         addr <= '0;
         done <= 1'b0;
      end else if (step && !done) begin
         if (addr == LAST) done <= 1'b1;
         else              addr <= addr + 1'b1;
      end
   end

   // R8
   addr_range_chk: assert property (@(posedge clk) disable iff (!por_n)
      addr <= LAST);

   // R8
   step_chk: assert property (@(posedge clk) disable iff (!por_n)
      (step && !done && !clear && addr != LAST) |=> addr == $past(addr) + 1'b1);

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      clear |=> (addr == '0 && !done));

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (done && !clear) |=> (done && addr == LAST));

endmodule

// File: rtl/cfgrd_store.sv
`timescale 1ns/1ps
module cfgrd_store #(
   parameter int               DEPTH = 48,
   parameter logic [DEPTH-1:0] IMAGE = '0,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [AW-1:0] addr,
   output logic          bit_o
);

   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [DEPTH-1:0] mem_bits;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign mem_bits[i] = IMAGE[i];
   end

   if (POW2) begin : g_full
      assign bit_o = mem_bits[addr];
   end else begin : g_guard
      always_comb begin
         bit_o = 1'b0;
         if (32'(addr) < DEPTH) bit_o = mem_bits[addr];
      end
   end

endmodule

// File: rtl/cfgrd_reader.sv
`timescale 1ns/1ps
module cfgrd_reader
   import cfgrd_pkg::*;
#(
   parameter int               DEPTH    = 48,
   parameter logic [DEPTH-1:0] IMAGE    = 48'hA5C3_0F96_E1B7,
   parameter logic [31:0]      CFG_WORD = 32'hFFFF_FFFF
) (
   input  logic clk,
   input  logic por_n,
   input  logic ce_n,
   input  logic rso,
   output logic data_pin,
   output logic data_drv,
   output logic cascade_n
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cfgrd_reader: DEPTH must be at least 2");
   end
   if (CFG_W != 32) begin : g_bad_cfg
      $error("cfgrd_reader: configuration word must hold four bytes");
   end

   logic          rst_seen;
   logic          rst_q;
   logic          stby_q;
   logic          done;
   logic          present;
   logic          cur_bit;
   logic [AW-1:0] addr;

   cfgrd_polarity #(.CFG_WORD(CFG_WORD)) u_pol (
      .clk      (clk),
      .por_n    (por_n),
      .rso      (rso),
      .rst_seen (rst_seen),
      .rst_q    (rst_q)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stby_q <= 1'b1;
      else        stby_q <= ce_n;
   end

   assign present = !rst_q && !stby_q && !done;

   cfgrd_counter #(.DEPTH(DEPTH)) u_ctr (
      .clk   (clk),
      .por_n (por_n),
      .clear (rst_seen),
      .step  (present),
      .addr  (addr),
      .done  (done)
   );

   cfgrd_store #(.DEPTH(DEPTH), .IMAGE(IMAGE)) u_store (
      .addr  (addr),
      .bit_o (cur_bit)
   );

   assign data_drv  = present;
   assign data_pin  = present ? cur_bit : 1'bz;
   assign cascade_n = !(done && !rst_q && !stby_q);

   // R5
   standby_chk: assert property (@(posedge clk) disable iff (!por_n)
      ce_n |=> (!data_drv && cascade_n));

   // R3
   reset_out_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_seen |=> (!data_drv && cascade_n));

   // R6
   handoff_chk: assert property (@(posedge clk) disable iff (!por_n)
      (present && addr == LAST && !rst_seen && !ce_n) |=> (!cascade_n && !data_drv));

   // R7
   no_contend_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(data_drv && !cascade_n));

endmodule

// File: tb/cfgrd_reader_test.sv
`timescale 1ns/1ps
module cfgrd_reader_test;

   localparam int          DEPTH = 48;
   localparam logic [47:0] IMG   = 48'h3C96_A50F_71E2;

   logic clk = 1'b0;
   logic por_n, ce_n, rso, rso_hi;
   logic data_pin, data_drv, cascade_n;
   logic hi_pin, hi_drv, hi_casc;

   int checks = 0;
   int fails  = 0;
   bit mon_on = 1'b0;
   logic exp_q[$];

   always #2.5 clk = ~clk;

   cfgrd_reader #(.DEPTH(DEPTH), .IMAGE(IMG), .CFG_WORD(32'hFFFF_FFFF)) uut (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .rso(rso),
      .data_pin(data_pin), .data_drv(data_drv), .cascade_n(cascade_n)
   );

   cfgrd_reader #(.DEPTH(DEPTH), .IMAGE(IMG), .CFG_WORD(32'h0000_0000)) uut_hi (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .rso(rso_hi),
      .data_pin(hi_pin), .data_drv(hi_drv), .cascade_n(hi_casc)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // reset_req selects the reset level on both instances; standby drives ce_n.
   task automatic drive(input bit reset_req, input bit standby);
      rso    = reset_req ? 1'b0 : 1'b1;
      rso_hi = reset_req ? 1'b1 : 1'b0;
      ce_n   = standby;
   endtask

   task automatic push_stream(input int first, input int last);
      for (int i = first; i <= last; i++) exp_q.push_back(IMG[i]);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (mon_on) begin
         check(data_drv == hi_drv, "R4 drive match", int'(hi_drv), int'(data_drv));
         if (data_drv) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected bit", 1, 0);
            end else begin
               logic e;
               e = exp_q.pop_front();
               check(data_pin == e, "R2 bit order", int'(data_pin), int'(e));
               check(hi_pin == e, "R4 bit order high-pol", int'(hi_pin), int'(e));
            end
         end
      end
   end

   initial begin
      por_n = 1'b0;
      drive(1'b1, 1'b1);
      tick(2);
      check(data_drv == 1'b0, "R1 drv", int'(data_drv), 0);
      check(cascade_n == 1'b1, "R1 cascade", int'(cascade_n), 1);
      check(hi_drv == 1'b0, "R1 drv high-pol", int'(hi_drv), 0);
      por_n = 1'b1;
      tick(1);

      // R4: same raw low level on both instances
      rso = 1'b0; rso_hi = 1'b0; ce_n = 1'b0;
      tick(1);
      check(data_drv == 1'b0, "R4 low level resets default", int'(data_drv), 0);
      check(hi_drv == 1'b1, "R4 low level enables high-pol", int'(hi_drv), 1);
      check(hi_pin == IMG[0], "R4 first bit high-pol", int'(hi_pin), int'(IMG[0]));
      drive(1'b1, 1'b0);
      tick(1);
      check(hi_drv == 1'b0, "R4 high level resets high-pol", int'(hi_drv), 0);
      mon_on = 1'b1;

      // R2/R6: full stream
      push_stream(0, DEPTH - 1);
      drive(1'b0, 1'b0);
      tick(DEPTH + 1);
      check(exp_q.size() == 0, "R2 all bits seen", exp_q.size(), 0);
      check(cascade_n == 1'b0, "R6 cascade low", int'(cascade_n), 0);
      check(data_drv == 1'b0, "R6 released", int'(data_drv), 0);
      tick(3);
      check(cascade_n == 1'b0, "R6 cascade held", int'(cascade_n), 0);
      check(data_drv == 1'b0, "R6 counter stopped", int'(data_drv), 0);

      // R7: standby after handoff
      drive(1'b0, 1'b1);
      tick(1);
      check(cascade_n == 1'b1, "R7 standby lifts cascade", int'(cascade_n), 1);
      check(data_drv == 1'b0, "R5 standby released", int'(data_drv), 0);
      drive(1'b0, 1'b0);
      tick(1);
      check(cascade_n == 1'b0, "R7 cascade back", int'(cascade_n), 0);

      // R3: reset ends cascade
      drive(1'b1, 1'b0);
      tick(1);
      check(cascade_n == 1'b1, "R7 reset lifts cascade", int'(cascade_n), 1);
      check(data_drv == 1'b0, "R3 reset released", int'(data_drv), 0);
      tick(2);
      check(data_drv == 1'b0, "R3 held in reset", int'(data_drv), 0);

      // R3: partial read, reset, restart from bit 0
      push_stream(0, 9);
      drive(1'b0, 1'b0);
      tick(10);
      drive(1'b1, 1'b0);
      tick(1);
      check(data_drv == 1'b0, "R3 mid-stream reset", int'(data_drv), 0);
      check(exp_q.size() == 0, "R3 partial bits seen", exp_q.size(), 0);
      push_stream(0, DEPTH - 1);
      drive(1'b0, 1'b0);
      tick(DEPTH + 1);
      check(exp_q.size() == 0, "R3 restart stream", exp_q.size(), 0);
      check(cascade_n == 1'b0, "R3 restart reaches end", int'(cascade_n), 0);

      // R5: standby mid-stream and resume
      drive(1'b1, 1'b0);
      tick(1);
      push_stream(0, DEPTH - 1);
      drive(1'b0, 1'b0);
      tick(5);
      drive(1'b0, 1'b1);
      for (int k = 0; k < 4; k++) begin
         tick(1);
         check(data_drv == 1'b0, "R5 standby mid-stream", int'(data_drv), 0);
         check(cascade_n == 1'b1, "R5 no handoff in standby", int'(cascade_n), 1);
      end
      drive(1'b0, 1'b0);
      tick(DEPTH - 5 + 1);
      check(exp_q.size() == 0, "R5 resume no loss", exp_q.size(), 0);
      check(cascade_n == 1'b0, "R6 handoff after resume", int'(cascade_n), 0);

      mon_on = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      fails++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule